// File: doc/BRIEF.md
# Framed Pseudo-Random Test Sequence Inserter

This block puts a pseudo-random test sequence onto a T1 or E1 transmit bit stream in place of the payload, one bit for each bit-enable pulse. A two-bit select picks one of four sequence lengths. An optional zero limiter stops long runs of zeros, and the run limit depends on the selected length. With the 2^20-1 length and the limiter on, the output is the quasi-random signal pattern, so no separate mode is needed for it.

In framed mode the block tracks its position in the frame with a bit counter. A frame-sync input aligns that counter. Protected positions pass the incoming bit through unchanged, and the generator holds still while they go by. In T1 the protected position is the single framing bit of each 193-bit frame. In E1 it is timeslot 0, plus timeslot 16 when signalling framing is on. A start input turns substitution on. While start is low the incoming data passes through and the generator is held at its seed.

Top module: `prbs_pattern_gen`

## Requirements
- R1: While rstN is low, and at the first clock after it is released, dataOut and patActive are 0.
- R2: The output takes each bit from a shift register that moves toward its MSB, with the new bit entering at bit 0. The output bit is the XOR of stages L and T (register bits L-1 and T-1). patSel 0 selects L=11, T=9; patSel 1 selects L=15, T=14; patSel 2 selects L=20, T=17; patSel 3 selects L=23, T=18. The register is reloaded to all ones whenever a bit is enabled with startEn low, so the first bit after a start is 0.
- R3: A bit enabled with startEn low sets dataOut to dataIn and patActive to 0 at the next clock edge.
- R4: With bitEn low, dataOut and patActive hold their values and the sequence does not advance.
- R5: With zeroLimEn 1 and patSel 0 or 1, a substituted bit is forced to 1 once 7 consecutive zeros have been substituted. The shift register advances as normal.
- R6: With zeroLimEn 1 and patSel 2 or 3, a substituted bit is forced to 1 once 14 consecutive zeros have been substituted.
- R7: patSel 2 with zeroLimEn 1 gives the quasi-random signal pattern. Its first 14 bits after start are 0 and its 15th bit is 1.
- R8: In framed mode with e1Mode 0, frame position 0 passes dataIn through with patActive 0, and the sequence does not advance on that bit.
- R9: In framed mode with e1Mode 1, positions 0 to 7 pass through. When casMode is also 1, positions 128 to 135 pass through as well. The sequence does not advance on any of these bits.
- R10: A bit enabled with frameSync 1 is position 0. Each later enabled bit increments the position, which wraps to 0 after 192 (T1) or 255 (E1).
- R11: With framedEn 0 and startEn 1, every enabled bit is substituted, with patActive 1.
- R12: The count of consecutive substituted zeros is held across passed-through bits. A protected bit that falls where a forced one is due delays the forced one to the next substituted bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | One-cycle strobe per line bit |
| frameSync | input | 1 | Marks the current bit as frame position 0 |
| e1Mode | input | 1 | 1 = E1 256-bit frame, 0 = T1 193-bit frame |
| casMode | input | 1 | E1 signalling framing; also protects timeslot 16 |
| patSel | input | 2 | Sequence length select |
| zeroLimEn | input | 1 | Zero-run limiter enable |
| framedEn | input | 1 | Preserve framing positions |
| startEn | input | 1 | Substitution on |
| dataIn | input | 1 | Incoming line bit |
| dataOut | output | 1 | Outgoing line bit, registered |
| patActive | output | 1 | Outgoing bit was substituted |

## Verification
A zero-limit force and a protected frame position can land on the same bit. Protection takes priority, and the force moves to the next substituted bit. The bench provokes this in T1 framed mode with the 2^11-1 length and the limiter on. It starts the sequence so that seven zeros build up, then pulses frameSync on the eighth bit. The bench checks that this bit carries dataIn and that the following bit is a forced 1. A bench model of counter, register and limiter predicts every output bit, and a checker asserts the zero-run bound on every substituted bit.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

  typedef enum logic [1:0] {
    PAT_LEN11 = 2'd0,
    PAT_LEN15 = 2'd1,
    PAT_LEN20 = 2'd2,
    PAT_LEN23 = 2'd3
  } patLen_e;

  localparam int NUM_PAT = 4;

  // strobes from control to datapath, valid in the cycle of a bit enable
  typedef struct packed {
    logic update;    // a line bit is produced this cycle
    logic advance;   // generator steps and drives the bit
    logic restart;   // reload seed and clear zero run
    logic passThru;  // incoming bit goes out unchanged
  } ctrlStrobe_t;

  function automatic int lenOf(input int idx);
    case (idx)
      0: return 11;
      1: return 15;
      2: return 20;
      default: return 23;
    endcase
  endfunction

  function automatic int tapOf(input int idx);
    case (idx)
      0: return 9;
      1: return 14;
      2: return 17;
      default: return 18;
    endcase
  endfunction

endpackage

// File: rtl/prbs_ctrl.sv
module prbs_ctrl
  import prbs_pkg::*;
#(
  parameter int T1_FRAME = 193,
  parameter int E1_FRAME = 256,
  parameter int TS_BITS  = 8,
  parameter int CAS_TS   = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitEn,
  input  logic        frameSync,
  input  logic        e1Mode,
  input  logic        casMode,
  input  logic        framedEn,
  input  logic        startEn,
  output ctrlStrobe_t strobe
);

  localparam int POS_W    = $clog2(E1_FRAME);
  localparam int CAS_LO   = CAS_TS * TS_BITS;
  localparam int CAS_HI   = CAS_LO + TS_BITS - 1;
  localparam logic [POS_W-1:0] T1_LAST = POS_W'(T1_FRAME - 1);
  localparam logic [POS_W-1:0] E1_LAST = POS_W'(E1_FRAME - 1);
  localparam logic [POS_W-1:0] TS0_END = POS_W'(TS_BITS - 1);
  localparam logic [POS_W-1:0] CAS_BEG = POS_W'(CAS_LO);
  localparam logic [POS_W-1:0] CAS_END = POS_W'(CAS_HI);

  logic [POS_W-1:0] posQ;
  logic [POS_W-1:0] curPos;
  logic [POS_W-1:0] lastPos;
  logic             t1Prot;
  logic             e1Prot;
  logic             casProt;
  logic             isProt;

  assign curPos  = frameSync ? '0 : posQ;
  assign lastPos = e1Mode ? E1_LAST : T1_LAST;

  assign t1Prot  = (curPos == '0);
  assign casProt = casMode && (curPos >= CAS_BEG) && (curPos <= CAS_END);
  assign e1Prot  = (curPos <= TS0_END) || casProt;
  assign isProt  = framedEn && (e1Mode ? e1Prot : t1Prot);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posQ <= '0;
    end else if (bitEn) begin
      posQ <= (curPos == lastPos) ? '0 : curPos + 1'b1;
    end
  end

  always_comb begin
    strobe.update   = bitEn;
    strobe.advance  = bitEn && startEn && !isProt;
    strobe.restart  = bitEn && !startEn;
    strobe.passThru = !(startEn && !isProt);
  end

endmodule

// File: rtl/prbs_datapath.sv
module prbs_datapath
  import prbs_pkg::*;
#(
  parameter int LFSR_W    = 23,
  parameter int SHORT_LIM = 7,
  parameter int LONG_LIM  = 14
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic [1:0]  patSel,
  input  logic        zeroLimEn,
  input  logic        dataIn,
  output logic        dataOut,
  output logic        patActive
);

  localparam int CNT_W = $clog2(LONG_LIM + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIM_S   = CNT_W'(SHORT_LIM);
  localparam logic [CNT_W-1:0] LIM_L   = CNT_W'(LONG_LIM);

  logic [LFSR_W-1:0]  lfsrQ;
  logic [NUM_PAT-1:0] fbVec;
  logic               fbBit;
  logic [CNT_W-1:0]   zeroCntQ;
  logic [CNT_W-1:0]   limit;
  logic               forceOne;
  logic               genBit;

  for (genvar g = 0; g < NUM_PAT; g++) begin : gTap
    localparam int LN = lenOf(g);
    localparam int TP = tapOf(g);
    assign fbVec[g] = lfsrQ[LN-1] ^ lfsrQ[TP-1];
  end

  assign fbBit    = fbVec[patSel];
  assign limit    = (patSel == PAT_LEN11 || patSel == PAT_LEN15) ? LIM_S : LIM_L;
  assign forceOne = zeroLimEn && (zeroCntQ >= limit);
  assign genBit   = forceOne | fbBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsrQ    <= '1;
      zeroCntQ <= '0;
    end else if (strobe.restart) begin
      lfsrQ    <= '1;
      zeroCntQ <= '0;
    end else if (strobe.advance) begin
      lfsrQ <= {lfsrQ[LFSR_W-2:0], fbBit};
      if (genBit)
        zeroCntQ <= '0;
      else if (zeroCntQ != CNT_MAX)
        zeroCntQ <= zeroCntQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut   <= 1'b0;
      patActive <= 1'b0;
    end else if (strobe.update) begin
      dataOut   <= strobe.passThru ? dataIn : genBit;
      patActive <= !strobe.passThru;
    end
  end

endmodule

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen
  import prbs_pkg::*;
#(
  parameter int T1_FRAME  = 193,
  parameter int E1_FRAME  = 256,
  parameter int TS_BITS   = 8,
  parameter int CAS_TS    = 16,
  parameter int LFSR_W    = 23,
  parameter int SHORT_LIM = 7,
  parameter int LONG_LIM  = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       frameSync,
  input  logic       e1Mode,
  input  logic       casMode,
  input  logic [1:0] patSel,
  input  logic       zeroLimEn,
  input  logic       framedEn,
  input  logic       startEn,
  input  logic       dataIn,
  output logic       dataOut,
  output logic       patActive
);

  ctrlStrobe_t strobe;

  prbs_ctrl #(
    .T1_FRAME(T1_FRAME),
    .E1_FRAME(E1_FRAME),
    .TS_BITS (TS_BITS),
    .CAS_TS  (CAS_TS)
  ) ctrlI (
    .clk      (clk),
    .rstN     (rstN),
    .bitEn    (bitEn),
    .frameSync(frameSync),
    .e1Mode   (e1Mode),
    .casMode  (casMode),
    .framedEn (framedEn),
    .startEn  (startEn),
    .strobe   (strobe)
  );

  prbs_datapath #(
    .LFSR_W   (LFSR_W),
    .SHORT_LIM(SHORT_LIM),
    .LONG_LIM (LONG_LIM)
  ) dpI (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .patSel   (patSel),
    .zeroLimEn(zeroLimEn),
    .dataIn   (dataIn),
    .dataOut  (dataOut),
    .patActive(patActive)
  );

endmodule

// File: rtl/prbs_pattern_gen_chk.sv
module prbs_pattern_gen_chk (
  input logic       clk,
  input logic       rstN,
  input logic       bitEn,
  input logic       frameSync,
  input logic       e1Mode,
  input logic [1:0] patSel,
  input logic       zeroLimEn,
  input logic       framedEn,
  input logic       startEn,
  input logic       dataIn,
  input logic       dataOut,
  input logic       patActive
);

  logic       updQ;
  logic       startQ;
  logic       zlQ;
  logic       shortQ;
  logic [4:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updQ   <= 1'b0;
      startQ <= 1'b0;
      zlQ    <= 1'b0;
      shortQ <= 1'b0;
    end else begin
      updQ   <= bitEn;
      startQ <= startEn;
      zlQ    <= zeroLimEn;
      shortQ <= (patSel < 2'd2);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (updQ) begin
      if (!startQ)
        runCnt <= '0;
      else if (patActive)
        runCnt <= dataOut ? 5'd0 : ((runCnt == 5'd31) ? runCnt : runCnt + 5'd1);
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (!dataOut && !patActive));

  // R3
  stop_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && !startEn) |=> (dataOut == $past(dataIn)) && !patActive);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(dataOut) && $stable(patActive));

  // R5
  short_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updQ && patActive && !dataOut && zlQ && shortQ) |-> (runCnt < 5'd7));

  // R6
  long_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updQ && patActive && !dataOut && zlQ && !shortQ) |-> (runCnt < 5'd14));

  // R8
  t1_frame_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && startEn && framedEn && !e1Mode && frameSync)
      |=> !patActive && (dataOut == $past(dataIn)));

  // R11
  unframed_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && startEn && !framedEn) |=> patActive);

endmodule

bind prbs_pattern_gen prbs_pattern_gen_chk chkI (
  .clk      (clk),
  .rstN     (rstN),
  .bitEn    (bitEn),
  .frameSync(frameSync),
  .e1Mode   (e1Mode),
  .patSel   (patSel),
  .zeroLimEn(zeroLimEn),
  .framedEn (framedEn),
  .startEn  (startEn),
  .dataIn   (dataIn),
  .dataOut  (dataOut),
  .patActive(patActive)
);

// File: tb/prbs_pattern_gen_test.sv
module prbs_pattern_gen_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0;
  logic       frameSync = 1'b0;
  logic       e1Mode = 1'b0;
  logic       casMode = 1'b0;
  logic [1:0] patSel = 2'd0;
  logic       zeroLimEn = 1'b0;
  logic       framedEn = 1'b0;
  logic       startEn = 1'b0;
  logic       dataIn = 1'b0;
  logic       dataOut;
  logic       patActive;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prbs_pattern_gen uut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameSync(frameSync),
    .e1Mode(e1Mode), .casMode(casMode), .patSel(patSel),
    .zeroLimEn(zeroLimEn), .framedEn(framedEn), .startEn(startEn),
    .dataIn(dataIn), .dataOut(dataOut), .patActive(patActive)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic        zl;
    logic        fr;
    logic        e1;
    logic        cas;
    logic [15:0] syncAt;
    logic [15:0] nBits;
    logic        gap;
  } scen_t;

  localparam int NSCEN = 8;
  localparam scen_t SCEN [NSCEN] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0, 16'd300, 1'b0},
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd0, 16'd300, 1'b0},
    '{2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 16'd0, 16'd400, 1'b0},
    '{2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 16'd0, 16'd400, 1'b0},
    '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 16'd0, 16'd420, 1'b0},
    '{2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 16'd0, 16'd600, 1'b0},
    '{2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 16'd5, 16'd600, 1'b1},
    '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 16'd7, 16'd200, 1'b0}
  };

  function automatic string scenTag(input int i);
    case (i)
      0: return "R2 R11";
      1: return "R5 R2";
      2: return "R7 R6";
      3: return "R6 R11";
      4: return "R8 R10";
      5: return "R9 R10";
      6: return "R9 casMode R4";
      default: return "R12 R8";
    endcase
  endfunction

  // bench model state
  logic [22:0] mLfsr = '1;
  int          mCnt  = 0;
  int          mPos  = 0;
  int          runZero = 0;
  int          maxRun  = 0;

  function automatic int lenM(input logic [1:0] s);
    case (s) 2'd0: return 11; 2'd1: return 15; 2'd2: return 20; default: return 23; endcase
  endfunction
  function automatic int tapM(input logic [1:0] s);
    case (s) 2'd0: return 9; 2'd1: return 14; 2'd2: return 17; default: return 18; endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // called at a negedge: drive one enabled bit, predict, then check at next negedge
  task automatic stepBit(input string tag, input logic sync, input logic start, input logic din);
    int  cur, last;
    bit  prot, fb, b;
    logic expD, expA;
    bitEn = 1'b1; frameSync = sync; startEn = start; dataIn = din;
    cur  = sync ? 0 : mPos;
    last = e1Mode ? 255 : 192;
    if (!framedEn) prot = 1'b0;
    else if (e1Mode) prot = (cur < 8) || (casMode && cur >= 128 && cur <= 135);
    else prot = (cur == 0);
    mPos = (cur == last) ? 0 : cur + 1;
    if (!start) begin
      expD = din; expA = 1'b0; mLfsr = '1; mCnt = 0; runZero = 0;
    end else if (prot) begin
      expD = din; expA = 1'b0;
    end else begin
      fb = mLfsr[lenM(patSel)-1] ^ mLfsr[tapM(patSel)-1];
      b  = fb | (zeroLimEn && mCnt >= ((patSel < 2'd2) ? 7 : 14));
      mLfsr = {mLfsr[21:0], fb};
      mCnt  = b ? 0 : mCnt + 1;
      runZero = b ? 0 : runZero + 1;
      if (runZero > maxRun) maxRun = runZero;
      expD = b; expA = 1'b1;
    end
    @(negedge clk);
    check(tag, dataOut, expD, "dataOut");
    check(tag, patActive, expA, "patActive");
    frameSync = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic keepD, keepA;
    repeat (3) @(negedge clk);
    // R1: outputs clear in reset
    check("R1", dataOut, 1'b0, "dataOut in reset");
    check("R1", patActive, 1'b0, "patActive in reset");
    rstN = 1'b1;
    @(negedge clk);
    check("R1", dataOut, 1'b0, "dataOut after reset");
    check("R1", patActive, 1'b0, "patActive after reset");

    for (int s = 0; s < NSCEN; s++) begin
      patSel = SCEN[s].sel; zeroLimEn = SCEN[s].zl; framedEn = SCEN[s].fr;
      e1Mode = SCEN[s].e1; casMode = SCEN[s].cas;
      maxRun = 0;
      // R3: stopped bit reseeds and passes data
      stepBit("R3", 1'b0, 1'b0, 1'b1);
      for (int i = 0; i < int'(SCEN[s].nBits); i++) begin
        stepBit(scenTag(s), (i == int'(SCEN[s].syncAt)), 1'b1, ((i % 5) == 2) || ((i % 7) == 0));
        if (SCEN[s].gap) begin
          keepD = dataOut; keepA = patActive;
          bitEn = 1'b0; dataIn = ~dataIn;
          @(negedge clk);
          // R4: idle cycle holds outputs
          check("R4", dataOut, keepD, "dataOut hold");
          check("R4", patActive, keepA, "patActive hold");
        end
      end
      bitEn = 1'b0;
      @(negedge clk);
      if (SCEN[s].zl) begin
        // R5 / R6 run bound over the whole scenario
        checks++;
        if (maxRun > ((SCEN[s].sel < 2'd2) ? 7 : 14)) begin
          errors++;
          $display("FAIL R5 R6 zero run actual=%0d expected<=%0d", maxRun,
                   (SCEN[s].sel < 2'd2) ? 7 : 14);
        end
      end
    end

    // R7: quasi-random pattern start: 14 zeros then a forced one
    patSel = 2'd2; zeroLimEn = 1'b1; framedEn = 1'b0;
    stepBit("R3", 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 14; i++) begin
      stepBit("R7", 1'b0, 1'b1, 1'b1);
      check("R7", dataOut, 1'b0, "early zero");
    end
    stepBit("R7", 1'b0, 1'b1, 1'b0);
    check("R7", dataOut, 1'b1, "forced one");

    // R3: stop mid-run, data follows input
    stepBit("R3", 1'b0, 1'b0, 1'b1);
    check("R3", dataOut, 1'b1, "stopped one");
    stepBit("R3", 1'b0, 1'b0, 1'b0);
    check("R3", dataOut, 1'b0, "stopped zero");
    bitEn = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule